// File: doc/BRIEF.md
# Pipelined Four-Operand Floating-Point Adder

This block adds four floating-point numbers in one fused operation and rounds the result once. A chain of two-input adders rounds after every step. The block avoids that by aligning all four significands to the largest exponent, reducing them with a carry-save stage and a carry-propagate stage, and rounding once at the end. The exponent and fraction widths are parameters. The default layout is 16 bits: sign in bit 15, an 8-bit exponent with bias 127 in bits 14:7, and a 7-bit fraction in bits 6:0.

The block is a three-stage pipeline with a valid bit that moves alongside the data.

- **Stage one** unpacks the operands, detects special values and aligns every significand to the largest exponent.
- **Stage two** applies the operand signs and compresses the four terms.
- **Stage three** finishes the addition, normalizes the sum, rounds it and assembles the output word.

A new set of operands may be presented on every clock. Subnormal encodings are read as zero and never produced. Only round-to-nearest-even is provided.

Top module: `fpa4_sum`

## Requirements
- R1: `out_valid` is high exactly three rising edges after the edge that samples `in_valid` high. Operand sets presented on consecutive cycles produce results on consecutive cycles. After reset, `out_valid` and `out_sum` are 0.
- R2: For normal operands, `out_sum` is the exact sum of the four operands rounded once to the output format.
- R3: The sign of each operand is honoured. A negative total gives a result with sign bit 15 set and the magnitude of the total.
- R4: A sum that cancels exactly returns +0 (0x0000).
- R5: Rounding is to nearest with ties to even. An operand shifted entirely below the extended width still counts toward the sticky information, so it breaks a tie upward.
- R6: If rounding carries out of the fraction, the exponent rises by one and the fraction becomes zero.
- R7: Any operand with exponent field 0 is treated as zero, whatever its fraction.
- R8: A result whose exponent would be 0 or below is returned as +0.
- R9: A finite result whose exponent reaches the all-ones value becomes an infinity with the sign of the total.
- R10: If no NaN is present and only one sign of infinity appears among the operands, the result is that infinity, whatever the finite operands are.
- R11: Any NaN operand (exponent all ones, fraction nonzero), or a mix of +infinity and -infinity, gives the canonical quiet NaN 0x7FC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operand set is valid this cycle |
| in_ops | input | 4 x (1+EXP_W+MAN_W) | Four packed operands; element 0 in the lowest bits |
| out_valid | output | 1 | Result is valid this cycle |
| out_sum | output | 1+EXP_W+MAN_W | Packed rounded sum |

## Verification
The bench targets the rounding boundary in three forms:
- an exact tie that must stay on an even fraction,
- a tie pushed upward by an operand far below the others, which a design that dropped shifted-out bits would round down,
- an all-ones fraction whose round-up must bump the exponent, which a design missing the carry would wrap to a too-small value.

Cancellation is tested as well:
- to exact zero, where a wrong design would return -0;
- to a value just under the smallest normal, which must flush;
- to exactly the smallest normal, which must survive.

Subnormal inputs that would add up to a normal value are tested, and a design without the zero-input rule would return a nonzero result. Infinity and NaN mixes are tested, where an unforced datapath would emit a finite or non-canonical value. Back-to-back operand sets are tested, where a stall or misaligned valid would shift results by a cycle.

// File: rtl/fpa4_pkg.sv
package fpa4_pkg;
  localparam int NOPS = 4;

  // special-value class carried down the pipeline
  typedef enum logic [1:0] {
    SP_NONE = 2'd0,
    SP_NAN  = 2'd1,
    SP_PINF = 2'd2,
    SP_NINF = 2'd3
  } spec_e;
endpackage

// File: rtl/fpa4_align.sv
module fpa4_align import fpa4_pkg::*; #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 7,
  parameter int GUARD = 22
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  input  logic [NOPS-1:0][EXP_W+MAN_W:0]       in_ops,
  output logic                                 s1_valid,
  output logic [EXP_W-1:0]                     s1_exp,
  output logic [NOPS-1:0][MAN_W+GUARD+1:0]     s1_al,
  output logic [NOPS-1:0]                      s1_sgn,
  output spec_e                                s1_spec
);
  localparam int W    = 1 + EXP_W + MAN_W;
  localparam int SIG_W = MAN_W + 1 + GUARD;
  localparam int AL_W  = SIG_W + 1;

  // shift right by the exponent gap, keep lost bits as a sticky LSB
  function automatic logic [AL_W-1:0] align_sig(input logic [SIG_W-1:0] sig,
                                                input logic [EXP_W-1:0] sh);
    logic [SIG_W-1:0] kept;
    logic [SIG_W-1:0] mask;
    logic             lost;
    if (int'(sh) >= SIG_W) begin
      kept = '0;
      lost = |sig;
    end else begin
      kept = sig >> sh;
      mask = ~({SIG_W{1'b1}} << sh);
      lost = |(sig & mask);
    end
    return {kept, lost};
  endfunction

  logic [EXP_W-1:0] ex     [NOPS];
  logic [MAN_W-1:0] fr     [NOPS];
  logic [SIG_W-1:0] sig    [NOPS];
  logic [NOPS-1:0]  is_nan, is_pinf, is_ninf, sg;
  logic [EXP_W-1:0] ex_max;
  logic [NOPS-1:0][AL_W-1:0] al_d;
  spec_e            spec_d;

  always_comb begin
    ex_max = '0;
    for (int i = 0; i < NOPS; i++) begin
      ex[i]      = in_ops[i][W-2 -: EXP_W];
      fr[i]      = in_ops[i][MAN_W-1:0];
      sg[i]      = in_ops[i][W-1];
      is_nan[i]  = (&ex[i]) && (fr[i] != '0);
      is_pinf[i] = (&ex[i]) && (fr[i] == '0) && !sg[i];
      is_ninf[i] = (&ex[i]) && (fr[i] == '0) &&  sg[i];
      // exponent field zero reads as zero (subnormals included)
      sig[i]     = (ex[i] == '0) ? '0 : {1'b1, fr[i], {GUARD{1'b0}}};
      if (ex[i] > ex_max) ex_max = ex[i];
    end
    for (int i = 0; i < NOPS; i++) begin
      al_d[i] = align_sig(sig[i], ex_max - ex[i]);
    end
    if ((|is_nan) || ((|is_pinf) && (|is_ninf))) spec_d = SP_NAN;
    else if (|is_pinf)                              spec_d = SP_PINF;
    else if (|is_ninf)                              spec_d = SP_NINF;
    else                                            spec_d = SP_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_exp   <= '0;
      s1_al    <= '0;
      s1_sgn   <= '0;
      s1_spec  <= SP_NONE;
    end else begin
      s1_valid <= in_valid;
      s1_exp   <= ex_max;
      s1_al    <= al_d;
      s1_sgn   <= sg;
      s1_spec  <= spec_d;
    end
  end

  // event wire: some aligned term carries its hidden bit in the top slot
  logic lead_present;
  always_comb begin
    lead_present = 1'b0;
    for (int i = 0; i < NOPS; i++) lead_present |= s1_al[i][AL_W-1];
  end

  // R2: the operand holding the largest exponent is never shifted
  a_r2_lead_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && (s1_al != '0)) |-> lead_present);
endmodule

// File: rtl/fpa4_reduce.sv
module fpa4_reduce import fpa4_pkg::*; #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 7,
  parameter int GUARD = 22
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              s1_valid,
  input  logic [EXP_W-1:0]                  s1_exp,
  input  logic [NOPS-1:0][MAN_W+GUARD+1:0]  s1_al,
  input  logic [NOPS-1:0]                   s1_sgn,
  input  spec_e                             s1_spec,
  output logic                              s2_valid,
  output logic [EXP_W-1:0]                  s2_exp,
  output logic [MAN_W+GUARD+4:0]            s2_ps,
  output logic [MAN_W+GUARD+4:0]            s2_pc,
  output spec_e                             s2_spec
);
  localparam int AL_W  = MAN_W + GUARD + 2;
  localparam int SUM_W = AL_W + 3;   // two growth bits plus sign

  // 3:2 compressor: returns {sum, carry}
  function automatic logic [2*SUM_W-1:0] csa3(input logic [SUM_W-1:0] a,
                                              input logic [SUM_W-1:0] b,
                                              input logic [SUM_W-1:0] c);
    logic [SUM_W-1:0] s;
    logic [SUM_W-1:0] cy;
    s  = a ^ b ^ c;
    cy = ((a & b) | (a & c) | (b & c)) << 1;
    return {s, cy};
  endfunction

  logic [SUM_W-1:0] term [NOPS];
  logic [2:0]       nneg;
  logic [SUM_W-1:0] corr;
  logic [SUM_W-1:0] s_a, c_a, s_b, c_b, s_c, c_c;

  always_comb begin
    nneg = '0;
    for (int i = 0; i < NOPS; i++) begin
      term[i] = s1_sgn[i] ? ~SUM_W'(s1_al[i]) : SUM_W'(s1_al[i]);
      nneg    = nneg + 3'(s1_sgn[i]);
    end
    // +1 per inverted term completes each two's-complement negation
    corr = SUM_W'(nneg);
    {s_a, c_a} = csa3(term[0], term[1], term[2]);
    {s_b, c_b} = csa3(s_a, c_a, term[3]);
    {s_c, c_c} = csa3(s_b, c_b, corr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_exp   <= '0;
      s2_ps    <= '0;
      s2_pc    <= '0;
      s2_spec  <= SP_NONE;
    end else begin
      s2_valid <= s1_valid;
      s2_exp   <= s1_exp;
      s2_ps    <= s_c;
      s2_pc    <= c_c;
      s2_spec  <= s1_spec;
    end
  end
endmodule

// File: rtl/fpa4_lzd.sv
module fpa4_lzd #(
  parameter int W = 33
) (
  input  logic [W-1:0]          vec,
  output logic [$clog2(W):0]    lz
);
  localparam int LG = $clog2(W);
  localparam int P  = 1 << LG;
  localparam int CW = LG + 1;

  // pairwise tree: each node merges an upper and a lower half
  function automatic logic [CW-1:0] lzd_tree(input logic [W-1:0] v);
    logic [P-1:0]  pv;
    logic          zf  [LG+1][P];
    logic [CW-1:0] cnt [LG+1][P];
    pv = P'(v) << (P - W);
    for (int l = 0; l <= LG; l++) begin
      for (int n = 0; n < P; n++) begin
        zf[l][n]  = 1'b1;
        cnt[l][n] = '0;
      end
    end
    for (int n = 0; n < P; n++) zf[0][n] = ~pv[P-1-n];
    for (int l = 1; l <= LG; l++) begin
      for (int n = 0; n < (P >> l); n++) begin
        zf[l][n] = zf[l-1][2*n] & zf[l-1][2*n+1];
        if (zf[l-1][2*n]) cnt[l][n] = CW'(1 << (l-1)) + cnt[l-1][2*n+1];
        else              cnt[l][n] = cnt[l-1][2*n];
      end
    end
    return zf[LG][0] ? CW'(W) : cnt[LG][0];
  endfunction

  assign lz = lzd_tree(vec);
endmodule

// File: rtl/fpa4_norm.sv
module fpa4_norm import fpa4_pkg::*; #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 7,
  parameter int GUARD = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s2_valid,
  input  logic [EXP_W-1:0]        s2_exp,
  input  logic [MAN_W+GUARD+4:0]  s2_ps,
  input  logic [MAN_W+GUARD+4:0]  s2_pc,
  input  spec_e                   s2_spec,
  output logic                    out_valid,
  output logic [EXP_W+MAN_W:0]    out_sum
);
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int SUM_W = MAN_W + GUARD + 5;
  localparam int MW    = SUM_W - 1;
  localparam int CW    = $clog2(MW) + 1;
  localparam int EW    = EXP_W + 3;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  function automatic logic [SUM_W-1:0] ripple(input logic [SUM_W-1:0] a,
                                               input logic [SUM_W-1:0] b);
    logic [SUM_W-1:0] r;
    logic             cy;
    cy = 1'b0;
    for (int i = 0; i < SUM_W; i++) begin
      r[i] = a[i] ^ b[i] ^ cy;
      cy   = (a[i] & b[i]) | (a[i] & cy) | (b[i] & cy);
    end
    return r;
  endfunction

  logic [SUM_W-1:0]     total, negt;
  logic                 neg;
  logic [MW-1:0]        mag, nrm;
  logic [CW-1:0]        lz;
  logic [MAN_W-1:0]     frac, frac_r;
  logic                 g_bit, st_bit, rnd, cout;
  logic signed [EW-1:0] e_raw;
  logic [W-1:0]         res_d;

  fpa4_lzd #(.W(MW)) u_lzd (.vec(mag), .lz(lz));

  always_comb begin
    total = ripple(s2_ps, s2_pc);
    neg   = total[SUM_W-1];
    negt  = ~total + SUM_W'(1);
    mag   = neg ? negt[MW-1:0] : total[MW-1:0];
    nrm   = mag << lz;
    frac  = nrm[MW-2 -: MAN_W];
    g_bit = nrm[MW-2-MAN_W];
    st_bit = |nrm[MW-3-MAN_W:0];
    rnd   = g_bit & (st_bit | frac[0]);
    {cout, frac_r} = {1'b0, frac} + (MAN_W+1)'(rnd);
    // unshifted hidden bit sits two places below the top of mag
    e_raw = $signed(EW'(s2_exp)) + $signed(EW'(2)) - $signed(EW'(lz))
          + $signed(EW'(cout));
    if (s2_spec == SP_NAN)       res_d = QNAN;
    else if (s2_spec == SP_PINF) res_d = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else if (s2_spec == SP_NINF) res_d = {1'b1, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else if (mag == '0)          res_d = '0;
    else if (e_raw <= 0)         res_d = '0;
    else if (e_raw >= $signed(EW'((1 << EXP_W) - 1)))
                                 res_d = {neg, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else                         res_d = {neg, e_raw[EXP_W-1:0], frac_r};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= s2_valid;
      out_sum   <= res_d;
    end
  end

  // R2: leading-zero count from the tree lines the shifter up on the top bit
  a_r2_norm_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && (mag != '0)) |-> nrm[MW-1]);

  // R8: no subnormal and no negative zero ever leaves the block
  a_r8_no_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_sum[W-2 -: EXP_W] == '0)) |-> (out_sum == '0));

  // R11: every NaN produced is the canonical one
  a_r11_canon_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&out_sum[W-2 -: EXP_W]) && (out_sum[MAN_W-1:0] != '0))
      |-> (out_sum == QNAN));
endmodule

// File: rtl/fpa4_sum.sv
module fpa4_sum import fpa4_pkg::*; #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 7,
  parameter int GUARD = 22
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [NOPS-1:0][EXP_W+MAN_W:0]  in_ops,
  output logic                            out_valid,
  output logic [EXP_W+MAN_W:0]            out_sum
);
  localparam int AL_W  = MAN_W + GUARD + 2;
  localparam int SUM_W = AL_W + 3;

  logic                      s1_valid, s2_valid;
  logic [EXP_W-1:0]          s1_exp, s2_exp;
  logic [NOPS-1:0][AL_W-1:0] s1_al;
  logic [NOPS-1:0]           s1_sgn;
  spec_e                     s1_spec, s2_spec;
  logic [SUM_W-1:0]          s2_ps, s2_pc;

  fpa4_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GUARD(GUARD)) u_align (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ops(in_ops),
    .s1_valid(s1_valid), .s1_exp(s1_exp), .s1_al(s1_al),
    .s1_sgn(s1_sgn), .s1_spec(s1_spec));

  fpa4_reduce #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GUARD(GUARD)) u_reduce (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_exp(s1_exp),
    .s1_al(s1_al), .s1_sgn(s1_sgn), .s1_spec(s1_spec),
    .s2_valid(s2_valid), .s2_exp(s2_exp), .s2_ps(s2_ps), .s2_pc(s2_pc),
    .s2_spec(s2_spec));

  fpa4_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GUARD(GUARD)) u_norm (
    .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_exp(s2_exp),
    .s2_ps(s2_ps), .s2_pc(s2_pc), .s2_spec(s2_spec),
    .out_valid(out_valid), .out_sum(out_sum));

  // R1: valid emerges exactly three edges after it enters
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 3));
endmodule

// File: tb/sim_fpa4_sum.sv
module sim_fpa4_sum;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [3:0][15:0]  in_ops = '0;
  logic              out_valid;
  logic [15:0]       out_sum;
  int                n_chk = 0;
  int                n_fail = 0;
  bit                done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  fpa4_sum u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ops(in_ops),
               .out_valid(out_valid), .out_sum(out_sum));

  task automatic check(input logic [15:0] got, input logic [15:0] expv,
                       input string req);
    n_chk++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, expv);
    end
  endtask

  // one operand set, result checked three edges later
  task automatic run_vec(input logic [15:0] a, b, c, d, expv, input string req);
    @(negedge clk);
    in_ops = {d, c, b, a}; in_valid = 1'b1;
    @(negedge clk);
    in_ops = '0; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({15'd0, out_valid}, 16'd1, {req, " valid"});
    check(out_sum, expv, req);
  endtask

  task automatic t_reset;
    check({15'd0, out_valid}, 16'd0, "R1 reset valid");
    check(out_sum, 16'h0000, "R1 reset sum");
  endtask

  task automatic t_latency;
    @(negedge clk);
    in_ops = {16'h3F80, 16'h3F80, 16'h3F80, 16'h3F80}; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check({15'd0, out_valid}, 16'd0, "R1 not yet after two edges");
    @(negedge clk);
    check({15'd0, out_valid}, 16'd1, "R1 valid after three edges");
    check(out_sum, 16'h4080, "R1 data with valid");
    @(negedge clk);
    check({15'd0, out_valid}, 16'd0, "R1 single-cycle valid");
  endtask

  task automatic t_stream;
    @(negedge clk); in_ops = {16'h0, 16'h0, 16'h3F80, 16'h3F80}; in_valid = 1'b1;
    @(negedge clk); in_ops = {16'h0, 16'h0, 16'h4000, 16'h4040};
    @(negedge clk); in_ops = {16'h0, 16'h0, 16'hBF80, 16'h3F00};
    @(negedge clk); in_valid = 1'b0; in_ops = '0;
    check(out_sum, 16'h4000, "R1 stream first");
    @(negedge clk);
    check({15'd0, out_valid}, 16'd1, "R1 stream second valid");
    check(out_sum, 16'h40A0, "R1 stream second");
    @(negedge clk);
    check(out_sum, 16'hBF00, "R1 stream third");
    @(negedge clk);
    check({15'd0, out_valid}, 16'd0, "R1 stream drained");
  endtask

  task automatic t_basic;
    run_vec(16'h3F80, 16'h4000, 16'h4040, 16'h4080, 16'h4120, "R2 1+2+3+4");
    run_vec(16'h3F80, 16'h3F80, 16'h3F80, 16'h3F80, 16'h4080, "R2 four ones");
  endtask

  task automatic t_signs;
    run_vec(16'hBF80, 16'hC000, 16'h0000, 16'h0000, 16'hC040, "R3 -1-2");
    run_vec(16'h4040, 16'hBF80, 16'hBF80, 16'h3F00, 16'h3FC0, "R3 3-1-1+0.5");
    run_vec(16'h3F80, 16'hC080, 16'h0000, 16'h0000, 16'hC040, "R3 1-4");
  endtask

  task automatic t_zero;
    run_vec(16'h3F80, 16'hBF80, 16'h4000, 16'hC000, 16'h0000, "R4 cancel");
    run_vec(16'hBF80, 16'h3F80, 16'hC000, 16'h4000, 16'h0000, "R4 cancel neg first");
  endtask

  task automatic t_round;
    run_vec(16'h3F80, 16'h3B80, 16'h0000, 16'h0000, 16'h3F80, "R5 tie even down");
    run_vec(16'h3F81, 16'h3B80, 16'h0000, 16'h0000, 16'h3F82, "R5 tie odd up");
    run_vec(16'h3F80, 16'h3B80, 16'h3B00, 16'h0000, 16'h3F81, "R5 above half");
    run_vec(16'h3F80, 16'h3B80, 16'h3080, 16'h0000, 16'h3F81, "R5 sticky far operand");
  endtask

  task automatic t_carry;
    run_vec(16'h3FFF, 16'h3B80, 16'h0000, 16'h0000, 16'h4000, "R6 round carry");
  endtask

  task automatic t_daz;
    run_vec(16'h0040, 16'h3F80, 16'h0000, 16'h0000, 16'h3F80, "R7 subnormal ignored");
    run_vec(16'h007F, 16'h007F, 16'h007F, 16'h007F, 16'h0000, "R7 four subnormals");
  endtask

  task automatic t_ftz;
    run_vec(16'h0100, 16'h80C0, 16'h0000, 16'h0000, 16'h0000, "R8 flush positive");
    run_vec(16'h8100, 16'h00C0, 16'h0000, 16'h0000, 16'h0000, "R8 flush to plus zero");
    run_vec(16'h0100, 16'h8080, 16'h0000, 16'h0000, 16'h0080, "R8 min normal kept");
  endtask

  task automatic t_ovf;
    run_vec(16'h7F7F, 16'h7F7F, 16'h0000, 16'h0000, 16'h7F80, "R9 overflow plus");
    run_vec(16'hFF7F, 16'hFF7F, 16'h0000, 16'h0000, 16'hFF80, "R9 overflow minus");
  endtask

  task automatic t_inf;
    run_vec(16'h7F80, 16'h3F80, 16'h0000, 16'h0000, 16'h7F80, "R10 plus inf");
    run_vec(16'hFF80, 16'h7F7F, 16'h7F7F, 16'h0000, 16'hFF80, "R10 minus inf");
  endtask

  task automatic t_nan;
    run_vec(16'h7FC1, 16'h3F80, 16'h0000, 16'h0000, 16'h7FC0, "R11 nan in");
    run_vec(16'h3F80, 16'h0000, 16'h0000, 16'hFFA0, 16'h7FC0, "R11 negative nan");
    run_vec(16'h7F80, 16'hFF80, 16'h0000, 16'h0000, 16'h7FC0, "R11 inf minus inf");
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_latency();
    t_stream();
    t_basic();
    t_signs();
    t_zero();
    t_round();
    t_carry();
    t_daz();
    t_ftz();
    t_ovf();
    t_inf();
    t_nan();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule